// File: doc/BRIEF.md
# Masked Two-Alarm Match Unit

This block watches a running clock and calendar and raises two alarm flags. It compares the current seconds, minutes, hours, date, month and weekday values against two banks of alarm settings. Each alarm field has its own compare-enable bit. A field whose enable is clear counts as matched. The first bank can test all six fields. The second bank tests minutes and hours, plus one more field that its settings make either the date or the weekday. The second bank only fires at the top of a minute.

The comparison runs once per one-hertz tick, on the time value that has just been updated. A match sets a sticky flag. The host can clear a flag but can never set it. An optional auto-clear mode clears both flags when the status read completes. The first alarm's flag can also pull an active-low interrupt line low, under three control bits. The time counters and the host bus are outside this block. The block receives the time values, the tick, the control bits and decoded clear strobes.

Top module: `alm_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, both flags read 0 and `irq_n` reads 1.
- R2: On a tick with `a1_on` = 1, `flag1` is set when every enabled first-bank field equals the matching clock value. The top bit of each alarm field input is its compare enable (1 = compare). The lower bits hold the BCD value, laid out as in the clock input. In the hour byte, bit 6 is the format bit and bits 5:0 hold the hour.
- R3: With `a1_on` = 1 and all six first-bank enables at 0, every tick sets `flag1`.
- R4: `flag2` can only be set on a tick whose seconds value is 00. With all second-bank enables at 0 it fires once per minute. Otherwise the enabled minute, hour and date/day fields must all match.
- R5: In `a2_dd`, bit 6 selects the field. When bit 6 is 1, bits 2:0 are compared with the weekday. When bit 6 is 0, bits 5:0 are compared with the date.
- R6: The format bit (bit 6) of an alarm hour byte must equal bit 6 of `cur_hour` (1 = 24-hour). If they differ, that alarm does not fire, whether or not its hour field is enabled.
- R7: An alarm whose global enable (`a1_on` or `a2_on`) is 0 never sets its flag.
- R8: Flags stay set until cleared. `clr_f1` and `clr_f2` each clear their own flag. If a set and a clear arrive in the same cycle, the set wins.
- R9: When `auto_clr` = 1, a `stat_rd_done` pulse clears both flags. When `auto_clr` = 0, the pulse has no effect.
- R10: `irq_n` is 0 exactly while `flag1`, `irq_en`, `irq_mode` and `a1_on` are all 1. `flag2` never drives it.
- R11: No flag is set in a cycle without a tick, even when all fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-hertz pulse; time inputs already hold the new second |
| cur_sec | input | 7 | Clock seconds, BCD |
| cur_min | input | 7 | Clock minutes, BCD |
| cur_hour | input | 7 | Bit 6 format (1 = 24 h), bits 5:0 hour BCD |
| cur_date | input | 6 | Clock date, BCD |
| cur_mon | input | 5 | Clock month, BCD |
| cur_dow | input | 3 | Clock weekday 0..6 |
| a1_sec | input | 8 | First bank seconds: enable + value |
| a1_min | input | 8 | First bank minutes: enable + value |
| a1_hour | input | 8 | First bank hour: enable, format, value |
| a1_date | input | 7 | First bank date: enable + value |
| a1_mon | input | 6 | First bank month: enable + value |
| a1_dow | input | 4 | First bank weekday: enable + value |
| a2_min | input | 8 | Second bank minutes: enable + value |
| a2_hour | input | 8 | Second bank hour: enable, format, value |
| a2_dd | input | 8 | Second bank date/day: enable, select, value |
| a1_on | input | 1 | First alarm global enable |
| a2_on | input | 1 | Second alarm global enable |
| irq_en | input | 1 | First alarm interrupt enable |
| irq_mode | input | 1 | Line used as interrupt (1) |
| auto_clr | input | 1 | Auto-clear flags on status read |
| clr_f1 | input | 1 | Host write clearing flag 1 |
| clr_f2 | input | 1 | Host write clearing flag 2 |
| stat_rd_done | input | 1 | Status read ended by a valid STOP |
| flag1 | output | 1 | Sticky first alarm flag |
| flag2 | output | 1 | Sticky second alarm flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a set and a clear that land on the same edge. The bench drives `clr_f1` in the same cycle as a matching tick and expects the flag to stay high. A second subtle case is an hour-format disagreement while the hour field is disabled. The bench sets the alarm format bit with the enable clear and expects no flag. It also separates date mode from weekday mode using an `a2_dd` value whose low three bits equal the weekday but whose six-bit value differs from the date.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int DATE_W = 6;
    localparam int MON_W  = 5;
    localparam int DOW_W  = 3;
    localparam int HCLK_W = HR_W + 1;
    localparam int BYTE_W = 8;
    localparam int FMT_BIT = 6;
    localparam int SEL_BIT = 6;
    localparam int N_ALM  = 2;

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [MIN_W-1:0]  min;
        logic [HCLK_W-1:0] hour;
        logic [DATE_W-1:0] date;
        logic [MON_W-1:0]  mon;
        logic [DOW_W-1:0]  dow;
    } clock_t;

    typedef struct packed {
        logic [SEC_W:0]   sec;
        logic [MIN_W:0]   min;
        logic [BYTE_W-1:0] hour;
        logic [DATE_W:0]  date;
        logic [MON_W:0]   mon;
        logic [DOW_W:0]   dow;
    } bank1_t;

    typedef struct packed {
        logic [MIN_W:0]    min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dd;
    } bank2_t;

    typedef enum logic {DD_DATE = 1'b0, DD_DOW = 1'b1} dd_sel_e;

    function automatic logic fmt_agree(input logic alm_hour_fmt, input logic clk_hour_fmt);
        return alm_hour_fmt == clk_hour_fmt;
    endfunction
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int W = 7
) (
    input  logic [W:0]   fld,
    input  logic [W-1:0] cur,
    output logic         ok
);
    always_comb ok = !fld[W] || (fld[W-1:0] == cur);
endmodule

// File: rtl/alm_bank1.sv
module alm_bank1
    import alm_pkg::*;
(
    input  clock_t t,
    input  bank1_t a,
    output logic   hit
);
    logic ok_s, ok_m, ok_h, ok_d, ok_mo, ok_w;
    logic fmt_ok;

    alm_field_cmp #(.W(SEC_W))  u_s  (.fld(a.sec),  .cur(t.sec),  .ok(ok_s));
    alm_field_cmp #(.W(MIN_W))  u_m  (.fld(a.min),  .cur(t.min),  .ok(ok_m));
    alm_field_cmp #(.W(HR_W))   u_h  (.fld({a.hour[BYTE_W-1], a.hour[HR_W-1:0]}),
                                      .cur(t.hour[HR_W-1:0]), .ok(ok_h));
    alm_field_cmp #(.W(DATE_W)) u_d  (.fld(a.date), .cur(t.date), .ok(ok_d));
    alm_field_cmp #(.W(MON_W))  u_mo (.fld(a.mon),  .cur(t.mon),  .ok(ok_mo));
    alm_field_cmp #(.W(DOW_W))  u_w  (.fld(a.dow),  .cur(t.dow),  .ok(ok_w));

    always_comb begin
        fmt_ok = fmt_agree(a.hour[FMT_BIT], t.hour[FMT_BIT]);
        hit    = fmt_ok && ok_s && ok_m && ok_h && ok_d && ok_mo && ok_w;
    end
endmodule

// File: rtl/alm_bank2.sv
module alm_bank2
    import alm_pkg::*;
(
    input  clock_t t,
    input  bank2_t a,
    output logic   hit
);
    logic ok_m, ok_h, ok_date, ok_dow, ok_dd;
    logic fmt_ok, top_of_min;
    dd_sel_e sel;

    alm_field_cmp #(.W(MIN_W))  u_m   (.fld(a.min), .cur(t.min), .ok(ok_m));
    alm_field_cmp #(.W(HR_W))   u_h   (.fld({a.hour[BYTE_W-1], a.hour[HR_W-1:0]}),
                                       .cur(t.hour[HR_W-1:0]), .ok(ok_h));
    alm_field_cmp #(.W(DATE_W)) u_dt  (.fld({a.dd[BYTE_W-1], a.dd[DATE_W-1:0]}),
                                       .cur(t.date), .ok(ok_date));
    alm_field_cmp #(.W(DOW_W))  u_dw  (.fld({a.dd[BYTE_W-1], a.dd[DOW_W-1:0]}),
                                       .cur(t.dow), .ok(ok_dow));

    always_comb begin
        sel        = dd_sel_e'(a.dd[SEL_BIT]);
        ok_dd      = (sel == DD_DOW) ? ok_dow : ok_date;
        fmt_ok     = fmt_agree(a.hour[FMT_BIT], t.hour[FMT_BIT]);
        top_of_min = (t.sec == '0);
        hit        = top_of_min && fmt_ok && ok_m && ok_h && ok_dd;
    end
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/alm_top.sv
module alm_top
    import alm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [SEC_W-1:0]    cur_sec,
    input  logic [MIN_W-1:0]    cur_min,
    input  logic [HCLK_W-1:0]   cur_hour,
    input  logic [DATE_W-1:0]   cur_date,
    input  logic [MON_W-1:0]    cur_mon,
    input  logic [DOW_W-1:0]    cur_dow,
    input  logic [SEC_W:0]      a1_sec,
    input  logic [MIN_W:0]      a1_min,
    input  logic [BYTE_W-1:0]   a1_hour,
    input  logic [DATE_W:0]     a1_date,
    input  logic [MON_W:0]      a1_mon,
    input  logic [DOW_W:0]      a1_dow,
    input  logic [MIN_W:0]      a2_min,
    input  logic [BYTE_W-1:0]   a2_hour,
    input  logic [BYTE_W-1:0]   a2_dd,
    input  logic                a1_on,
    input  logic                a2_on,
    input  logic                irq_en,
    input  logic                irq_mode,
    input  logic                auto_clr,
    input  logic                clr_f1,
    input  logic                clr_f2,
    input  logic                stat_rd_done,
    output logic                flag1,
    output logic                flag2,
    output logic                irq_n
);
    clock_t t;
    bank1_t b1;
    bank2_t b2;
    logic   hit1, hit2;
    logic [N_ALM-1:0] set_v, clr_v, flg_v, on_v, hit_v, hclr_v;
    logic   auto_hit;

    always_comb begin
        t  = '{sec: cur_sec, min: cur_min, hour: cur_hour,
               date: cur_date, mon: cur_mon, dow: cur_dow};
        b1 = '{sec: a1_sec, min: a1_min, hour: a1_hour,
               date: a1_date, mon: a1_mon, dow: a1_dow};
        b2 = '{min: a2_min, hour: a2_hour, dd: a2_dd};
    end

    alm_bank1 u_b1 (.t(t), .a(b1), .hit(hit1));
    alm_bank2 u_b2 (.t(t), .a(b2), .hit(hit2));

    always_comb begin
        auto_hit = auto_clr && stat_rd_done;
        on_v     = {a2_on, a1_on};
        hit_v    = {hit2, hit1};
        hclr_v   = {clr_f2, clr_f1};
    end

    for (genvar g = 0; g < N_ALM; g++) begin : g_flag
        always_comb begin
            set_v[g] = tick && on_v[g] && hit_v[g];
            clr_v[g] = hclr_v[g] || auto_hit;
        end
        alm_flag u_f (.clk(clk), .rst(rst), .set(set_v[g]), .clr(clr_v[g]), .q(flg_v[g]));
    end

    always_comb begin
        flag1 = flg_v[0];
        flag2 = flg_v[1];
        irq_n = !(flg_v[0] && irq_en && irq_mode && a1_on);
    end
endmodule

// File: rtl/alm_chk.sv
module alm_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [6:0] cur_sec,
    input logic [6:0] cur_hour,
    input logic [7:0] a1_hour,
    input logic       a1_on,
    input logic       auto_clr,
    input logic       clr_f1,
    input logic       stat_rd_done,
    input logic       flag1,
    input logic       flag2,
    input logic       irq_n
);
    assert_reset_R1: assert property (@(posedge clk) rst |=> (!flag1 && !flag2));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (flag1 && !clr_f1 && !(auto_clr && stat_rd_done)) |=> flag1);

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_f1 && !tick) |=> !flag1);

    assert_tick_only_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(flag1) |-> $past(tick));

    assert_top_of_min_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flag2) |-> ($past(cur_sec) == 7'h00));

    assert_fmt_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && (a1_hour[6] != cur_hour[6]) && !flag1) |=> !flag1);

    assert_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!a1_on && !flag1) |=> !flag1);

    assert_auto_R9: assert property (@(posedge clk) disable iff (rst)
        (auto_clr && stat_rd_done && !tick) |=> (!flag1 && !flag2));

    assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (flag1 && a1_on));
endmodule

bind alm_top alm_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cur_sec(cur_sec), .cur_hour(cur_hour),
    .a1_hour(a1_hour), .a1_on(a1_on), .auto_clr(auto_clr), .clr_f1(clr_f1),
    .stat_rd_done(stat_rd_done), .flag1(flag1), .flag2(flag2), .irq_n(irq_n)
);

// File: tb/sim_alm_top.sv
module sim_alm_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, tick;
    logic [6:0] cur_sec, cur_min, cur_hour;
    logic [5:0] cur_date;
    logic [4:0] cur_mon;
    logic [2:0] cur_dow;
    logic [7:0] a1_sec, a1_min, a1_hour, a2_min, a2_hour, a2_dd;
    logic [6:0] a1_date;
    logic [5:0] a1_mon;
    logic [3:0] a1_dow;
    logic a1_on, a2_on, irq_en, irq_mode, auto_clr, clr_f1, clr_f2, stat_rd_done;
    logic flag1, flag2, irq_n;

    int total = 0;
    int bad = 0;

    alm_top u0 (.*);

    typedef struct packed {
        logic [7:0] s, m, h, d, mo, w;
        logic [7:0] a1s, a1m, a1h, a1d, a1mo, a1w;
        logic [7:0] a2m, a2h, a2d;
        logic e1, e2;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        '{8'h56,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b1,1'b0},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b1,1'b1},
        '{8'h30,8'h34,8'h12,8'h15,8'h06,8'h03, 8'hB0,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b1,1'b0},
        '{8'h30,8'h34,8'h12,8'h15,8'h06,8'h03, 8'hB1,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b0,1'b0},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'hB4,8'h92,8'h55,8'h26,8'h0B, 8'hB4,8'h92,8'h95, 1'b1,1'b1},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'hB4,8'h92,8'h55,8'h27,8'h0B, 8'hB4,8'h92,8'hC3, 1'b0,1'b1},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'hC4, 1'b1,1'b0},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00, 8'h00,8'h00,8'h83, 1'b1,1'b0},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'hD2,8'h00,8'h00,8'h00, 8'h00,8'hD2,8'h00, 1'b0,1'b0},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h40,8'h00,8'h00,8'h00, 8'h00,8'h40,8'h00, 1'b0,1'b0},
        '{8'h00,8'h34,8'h63,8'h15,8'h06,8'h03, 8'h00,8'h00,8'hE3,8'h00,8'h00,8'h00, 8'h00,8'hE3,8'h00, 1'b1,1'b1},
        '{8'h00,8'h34,8'h12,8'h15,8'h06,8'h03, 8'h00,8'h00,8'h00,8'h00,8'h00,8'h00, 8'hB5,8'h00,8'h00, 1'b1,1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        cur_sec = v.s[6:0]; cur_min = v.m[6:0]; cur_hour = v.h[6:0];
        cur_date = v.d[5:0]; cur_mon = v.mo[4:0]; cur_dow = v.w[2:0];
        a1_sec = v.a1s; a1_min = v.a1m; a1_hour = v.a1h;
        a1_date = v.a1d[6:0]; a1_mon = v.a1mo[5:0]; a1_dow = v.a1w[3:0];
        a2_min = v.a2m; a2_hour = v.a2h; a2_dd = v.a2d;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic clear_both();
        @(negedge clk) begin clr_f1 = 1'b1; clr_f2 = 1'b1; end
        @(negedge clk) begin clr_f1 = 1'b0; clr_f2 = 1'b0; end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst = 1'b1; tick = 1'b0;
        a1_on = 1'b0; a2_on = 1'b0; irq_en = 1'b0; irq_mode = 1'b0;
        auto_clr = 1'b0; clr_f1 = 1'b0; clr_f2 = 1'b0; stat_rd_done = 1'b0;
        load(VT[0]);
        idle(3);
        chk("R1 flag1 in reset", flag1, 1'b0);
        chk("R1 flag2 in reset", flag2, 1'b0);
        chk("R1 irq_n in reset", irq_n, 1'b1);
        @(negedge clk) rst = 1'b0;
        chk("R1 flag1 after reset", flag1, 1'b0);
        chk("R1 irq_n after reset", irq_n, 1'b1);

        // R2 R3 R4 R5 R6: table walk
        a1_on = 1'b1; a2_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            load(VT[i]);
            clear_both();
            pulse_tick();
            chk($sformatf("R2/R3/R6 vec%0d flag1", i), flag1, VT[i].e1);
            chk($sformatf("R4/R5/R6 vec%0d flag2", i), flag2, VT[i].e2);
        end

        // R11: everything matches but no tick
        load(VT[1]);
        clear_both();
        idle(5);
        chk("R11 flag1 without tick", flag1, 1'b0);
        chk("R11 flag2 without tick", flag2, 1'b0);

        // R7: global enables off
        a1_on = 1'b0; a2_on = 1'b0;
        pulse_tick();
        chk("R7 flag1 with a1_on=0", flag1, 1'b0);
        chk("R7 flag2 with a2_on=0", flag2, 1'b0);
        a1_on = 1'b1; a2_on = 1'b1;

        // R8: sticky, clear, set wins
        pulse_tick();
        idle(4);
        chk("R8 flag1 sticky", flag1, 1'b1);
        chk("R8 flag2 sticky", flag2, 1'b1);
        @(negedge clk) clr_f1 = 1'b1;
        @(negedge clk) clr_f1 = 1'b0;
        chk("R8 flag1 cleared", flag1, 1'b0);
        chk("R8 flag2 untouched by clr_f1", flag2, 1'b1);
        @(negedge clk) begin tick = 1'b1; clr_f1 = 1'b1; end
        @(negedge clk) begin tick = 1'b0; clr_f1 = 1'b0; end
        chk("R8 set wins over same-cycle clear", flag1, 1'b1);

        // R9: auto-clear
        auto_clr = 1'b0;
        @(negedge clk) stat_rd_done = 1'b1;
        @(negedge clk) stat_rd_done = 1'b0;
        chk("R9 flag1 kept when auto_clr=0", flag1, 1'b1);
        chk("R9 flag2 kept when auto_clr=0", flag2, 1'b1);
        auto_clr = 1'b1;
        @(negedge clk) stat_rd_done = 1'b1;
        @(negedge clk) stat_rd_done = 1'b0;
        chk("R9 flag1 auto cleared", flag1, 1'b0);
        chk("R9 flag2 auto cleared", flag2, 1'b0);
        auto_clr = 1'b0;

        // R10: interrupt gating
        pulse_tick();
        irq_en = 1'b1; irq_mode = 1'b1;
        @(negedge clk);
        chk("R10 irq_n low with all enables", irq_n, 1'b0);
        irq_mode = 1'b0; @(negedge clk);
        chk("R10 irq_n released irq_mode=0", irq_n, 1'b1);
        irq_mode = 1'b1; irq_en = 1'b0; @(negedge clk);
        chk("R10 irq_n released irq_en=0", irq_n, 1'b1);
        irq_en = 1'b1; a1_on = 1'b0; @(negedge clk);
        chk("R10 irq_n released a1_on=0", irq_n, 1'b1);
        a1_on = 1'b1; @(negedge clk);
        chk("R10 irq_n low again", irq_n, 1'b0);
        @(negedge clk) clr_f1 = 1'b1;
        @(negedge clk) clr_f1 = 1'b0;
        chk("R10 irq_n released on flag clear", irq_n, 1'b1);
        chk("R10 flag2 still set", flag2, 1'b1);
        chk("R10 flag2 alone does not drive irq", irq_n, 1'b1);

        summary();
    end
endmodule